// File: doc/BRIEF.md
# Packet-ending streaming FIFO writer

This block sits between an internal data source and an external slave-FIFO style bridge. Words arrive on a valid/ready stream, wait in a small local FIFO, and leave towards the bridge through an active-low write strobe with the word on a parallel data bus. The bridge reports through a ready flag whether it can take data. That flag passes through a two-flop synchronizer, and the block keeps writing one word per clock for as long as the synchronized flag is high.

A packet can be closed before it reaches its maximum size. Closing happens on a `flush_req` pulse or when a programmable period passes with no packet end on the bus. The block then drives the active-low packet-end strobe together with the write that carries the last word held at the moment the request was accepted. If the bytes sent since the last packet boundary already form whole maximum-size packets, a separate packet-end pulse with no write (a zero-length packet) closes the transfer instead. A request that finds nothing to close leaves the bus idle.

The input stream follows these back-pressure rules. `in_ready` is high whenever the local FIFO has room, and a word transfers on a clock edge where `in_valid` and `in_ready` are both high. The source is a producer that cannot be stalled, so a word offered while `in_ready` is low is not held: it is dropped. Each drop sets a sticky overflow flag and advances a saturating drop counter.

Top module: `pkt_flush_writer`

## Requirements
- R1: Every word accepted on the input stream appears exactly once on `bus_data`, with `bus_wr_n` low, in acceptance order. Dropped words never appear.
- R2: While the synchronized ready is high and the FIFO holds data, writes occur on consecutive cycles with no idle cycle between words.
- R3: No write strobe is driven later than `SYNC_STAGES` cycles after `bus_rdy` goes low. Words stay queued until ready returns.
- R4: When an end request is accepted with N > 0 words queued, the N-th following write carries `bus_pktend_n` low in the same cycle as `bus_wr_n` low, unless R6 applies.
- R5: When `PERIOD_CYC` cycles pass with no packet-end strobe on the bus, an end request is raised internally.
- R6: When the bytes written since the last boundary are a nonzero whole multiple of `MAX_PKT_BYTES`, a zero-length packet is emitted: one cycle with `bus_pktend_n` low and `bus_wr_n` high. This includes the case where the last queued word of a request completes a full packet; that word is written with `bus_pktend_n` high and the zero-length packet follows.
- R7: An end request accepted with an empty FIFO, while a partial packet has already been written, produces one packet-end pulse without a write.
- R8: An end request accepted when nothing was written since the previous packet end produces no strobe at all. No two packet-end pulses without a write are ever adjacent.
- R9: A word offered while `in_ready` is low is discarded, and `overflow` is set and stays set until reset.
- R10: `drop_cnt` advances by one per discarded word, holds at all ones, and is cleared only by reset.
- R11: After reset, `bus_wr_n` and `bus_pktend_n` are high, `in_ready` is high, `overflow` is low and `drop_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Local FIFO has room |
| in_data | input | DW | Input word |
| flush_req | input | 1 | One-cycle request to end the current packet |
| bus_rdy | input | 1 | Bridge can accept data (asynchronous to the write decision) |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_pktend_n | output | 1 | Packet-end strobe, active low |
| bus_data | output | DW | Data word for the bridge |
| overflow | output | 1 | Sticky: at least one word was dropped |
| drop_cnt | output | DROP_W | Saturating count of dropped words |

## Verification
The hardest situation to reach from the ports is an end request whose final queued word exactly completes a maximum-size packet. Reaching it needs the request to be accepted while a whole packet's worth of words sits in the FIFO and none of them has left yet. The bench holds `bus_rdy` low past the synchronizer latency, loads exactly one packet of words, pulses `flush_req` and only then releases ready. It then expects a clean write burst followed by a bare packet-end pulse. A similar ready hold, with more words offered than the FIFO can keep, drives the drop counter into saturation.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WRITE     = 2'd1,
    ST_SHORT_END = 2'd2,
    ST_ZLP       = 2'd3
  } pfw_state_e;

endpackage

// File: rtl/pfw_fifo.sv
module pfw_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pfw_sync.sv
module pfw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
    end else begin
      sh[0] <= d;
      for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pfw_period_timer.sv
module pfw_period_timer #(
  parameter int PERIOD = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int TW = $clog2(PERIOD+1);

  logic [TW-1:0] cnt;

  assign tick = (cnt == TW'(PERIOD-1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (tick || restart)  cnt <= '0;
    else                       cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/pfw_ctrl.sv
module pfw_ctrl
  import pfw_pkg::*;
#(
  parameter int DW            = 32,
  parameter int DEPTH         = 16,
  parameter int MAX_PKT_BYTES = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rdy_ok,
  input  logic                       fifo_empty,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input  logic                       end_req,
  output logic                       do_wr,
  output logic                       do_end
);
  localparam int WB  = DW / 8;
  localparam int BCW = $clog2(MAX_PKT_BYTES+1);
  localparam int CW  = $clog2(DEPTH+1);

  pfw_state_e     state, state_d;
  logic [CW-1:0]  rem_q, rem_d, rem_eff;
  logic           pend;
  logic [BCW-1:0] bytecnt;
  logic [BCW:0]   bytesum;
  logic           last_ended;
  logic           accept, can_wr, ending, final_wr, fills, zlp_fire;

  assign accept   = pend && (state == ST_IDLE || state == ST_WRITE);
  assign can_wr   = rdy_ok && !fifo_empty && (state != ST_ZLP);
  assign rem_eff  = (state == ST_SHORT_END) ? rem_q : fifo_count;
  assign ending   = accept || (state == ST_SHORT_END);
  assign final_wr = ending && can_wr && (rem_eff == CW'(1));
  assign bytesum  = {1'b0, bytecnt} + (BCW+1)'(WB);
  assign fills    = (bytesum == (BCW+1)'(MAX_PKT_BYTES));
  assign zlp_fire = (state == ST_ZLP) && rdy_ok;

  assign do_wr  = can_wr;
  assign do_end = (final_wr && !fills) || zlp_fire;

  always_comb begin
    state_d = state;
    rem_d   = rem_q;
    case (state)
      ST_IDLE, ST_WRITE: begin
        if (accept && fifo_count == '0) begin
          state_d = (bytecnt != '0 || !last_ended) ? ST_ZLP : ST_IDLE;
        end else if (accept) begin
          if (final_wr) begin
            state_d = fills ? ST_ZLP : ST_WRITE;
          end else begin
            state_d = ST_SHORT_END;
            rem_d   = fifo_count - CW'(do_wr);
          end
        end else begin
          state_d = can_wr ? ST_WRITE : ST_IDLE;
        end
      end
      ST_SHORT_END: begin
        if (final_wr) state_d = fills ? ST_ZLP : ST_WRITE;
        else          rem_d   = rem_q - CW'(do_wr);
      end
      ST_ZLP: begin
        if (zlp_fire) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rem_q      <= '0;
      pend       <= 1'b0;
      bytecnt    <= '0;
      last_ended <= 1'b1;
    end else begin
      state <= state_d;
      rem_q <= rem_d;
      pend  <= (pend && !accept) || end_req;
      if (do_end) begin
        bytecnt    <= '0;
        last_ended <= 1'b1;
      end else if (do_wr) begin
        bytecnt    <= fills ? '0 : bytesum[BCW-1:0];
        last_ended <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_flush_writer.sv
module pkt_flush_writer #(
  parameter int DW            = 32,
  parameter int FIFO_DEPTH    = 16,
  parameter int MAX_PKT_BYTES = 512,
  parameter int PERIOD_CYC    = 50_000_000,
  parameter int SYNC_STAGES   = 2,
  parameter int DROP_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              flush_req,
  input  logic              bus_rdy,
  output logic              bus_wr_n,
  output logic              bus_pktend_n,
  output logic [DW-1:0]     bus_data,
  output logic              overflow,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic          push, fifo_full, fifo_empty, rdy_s, tick, end_req, do_wr, do_end;
  logic [DW-1:0] head;
  logic [CW-1:0] fifo_count;

  assign in_ready = !fifo_full;
  assign push     = in_valid && in_ready;
  assign end_req  = tick || flush_req;

  pfw_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_data), .pop(do_wr),
    .head(head), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  pfw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_rdy), .q(rdy_s)
  );

  pfw_period_timer #(.PERIOD(PERIOD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(do_end), .tick(tick)
  );

  pfw_ctrl #(.DW(DW), .DEPTH(FIFO_DEPTH), .MAX_PKT_BYTES(MAX_PKT_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdy_ok(rdy_s), .fifo_empty(fifo_empty),
    .fifo_count(fifo_count), .end_req(end_req), .do_wr(do_wr), .do_end(do_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_wr_n     <= 1'b1;
      bus_pktend_n <= 1'b1;
      bus_data     <= '0;
    end else begin
      bus_wr_n     <= !do_wr;
      bus_pktend_n <= !do_end;
      if (do_wr) bus_data <= head;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow <= 1'b0;
      drop_cnt <= '0;
    end else if (in_valid && !in_ready) begin
      overflow <= 1'b1;
      if (drop_cnt != '1) drop_cnt <= drop_cnt + DROP_W'(1);
    end
  end
endmodule

// File: rtl/pfw_checker.sv
module pfw_checker #(
  parameter int SYNC_STAGES = 2,
  parameter int DROP_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              bus_rdy,
  input logic              bus_wr_n,
  input logic              bus_pktend_n,
  input logic              overflow,
  input logic [DROP_W-1:0] drop_cnt
);
  a_r3_no_write_unready: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> $past(bus_rdy, SYNC_STAGES+1));

  a_r9_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && drop_cnt != '1) |=> (drop_cnt == $past(drop_cnt) + DROP_W'(1)));

  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && !in_ready) || drop_cnt == '1) |=> $stable(drop_cnt));

  a_r8_no_double_zlp: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_pktend_n && bus_wr_n) |=> !(!bus_pktend_n && bus_wr_n));
endmodule

bind pkt_flush_writer pfw_checker #(.SYNC_STAGES(SYNC_STAGES), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .bus_rdy(bus_rdy), .bus_wr_n(bus_wr_n), .bus_pktend_n(bus_pktend_n),
  .overflow(overflow), .drop_cnt(drop_cnt)
);

// File: tb/tb_pkt_flush_writer.sv
`timescale 1ns/1ps
module tb_pkt_flush_writer;
  localparam int DW     = 32;
  localparam int DEPTH  = 16;
  localparam int MAXB   = 64;
  localparam int PERIOD = 1000;
  localparam int DROPW  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, flush_req = 1'b0, bus_rdy = 1'b1;
  logic [DW-1:0] in_data = '0, bus_data;
  logic bus_wr_n, bus_pktend_n, overflow;
  logic [DROPW-1:0] drop_cnt;

  pkt_flush_writer #(.DW(DW), .FIFO_DEPTH(DEPTH), .MAX_PKT_BYTES(MAXB),
                     .PERIOD_CYC(PERIOD), .SYNC_STAGES(2), .DROP_W(DROPW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .flush_req(flush_req), .bus_rdy(bus_rdy),
    .bus_wr_n(bus_wr_n), .bus_pktend_n(bus_pktend_n), .bus_data(bus_data),
    .overflow(overflow), .drop_cnt(drop_cnt)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 1'b0;
  // event log: kind 0 = write, 1 = write with end, 2 = end without write
  int ev_kind [0:1023];
  int ev_data [0:1023];
  int ev_cyc  [0:1023];
  int n_ev = 0;
  int exp_w [0:1023];
  int n_exp = 0;
  int next_val = 32'h100;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && (!bus_wr_n || !bus_pktend_n) && n_ev < 1024) begin
      ev_kind[n_ev] = !bus_wr_n ? (!bus_pktend_n ? 1 : 0) : 2;
      ev_data[n_ev] = int'(bus_data);
      ev_cyc[n_ev]  = cyc;
      n_ev = n_ev + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(next_val);
      if (in_ready) begin
        exp_w[n_exp] = next_val;
        n_exp++;
      end
      next_val++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 0;
  endtask

  task automatic set_rdy(input logic v);
    @(negedge clk); bus_rdy = v;
  endtask

  // compares n logged events from base with expected words from e0
  task automatic check_burst(input string req, input int base, input int e0,
                             input int n, input bit end_last);
    int bad = 0;
    chk(req, "logged event count", (n_ev - base >= n) ? n : n_ev - base, n);
    for (int i = 0; i < n; i++) begin
      if (base + i < n_ev) begin
        if (ev_data[base+i] != exp_w[e0+i]) bad++;
        if (ev_kind[base+i] != ((i == n-1 && end_last) ? 1 : 0)) bad++;
      end
    end
    chk(req, "data or strobe mismatches", bad, 0);
  endtask

  task automatic t_reset();
    chk("R11", "bus_wr_n after reset", int'(bus_wr_n), 1);
    chk("R11", "bus_pktend_n after reset", int'(bus_pktend_n), 1);
    chk("R11", "in_ready after reset", int'(in_ready), 1);
    chk("R11", "overflow after reset", int'(overflow), 0);
    chk("R11", "drop_cnt after reset", int'(drop_cnt), 0);
  endtask

  task automatic t_stream();
    int base = n_ev, e0 = n_exp, gaps = 0;
    send(40);
    idle(10);
    check_burst("R1", base, e0, 40, 1'b0);
    for (int i = 1; i < 40; i++)
      if (base + i < n_ev && ev_cyc[base+i] != ev_cyc[base+i-1] + 1) gaps++;
    chk("R2", "idle cycles inside burst", gaps, 0);
    chk("R2", "events after burst", n_ev - base, 40);
    flush();
    idle(10);
    chk("R7", "events after flush of partial", n_ev - base, 41);
    chk("R7", "kind of closing event", (n_ev > base + 40) ? ev_kind[base+40] : -1, 2);
  endtask

  task automatic t_short_end();
    int base, e0;
    set_rdy(1'b0);
    idle(4);
    base = n_ev; e0 = n_exp;
    send(6);
    idle(10);
    chk("R3", "writes while not ready", n_ev - base, 0);
    flush();
    idle(3);
    set_rdy(1'b1);
    idle(12);
    check_burst("R4", base, e0, 6, 1'b1);
    chk("R4", "extra events", n_ev - base, 6);
  endtask

  task automatic t_full_then_zlp();
    int base = n_ev, e0 = n_exp;
    send(16);
    idle(6);
    check_burst("R6", base, e0, 16, 1'b0);
    flush();
    idle(8);
    chk("R6", "events after full packet end", n_ev - base, 17);
    chk("R6", "zero-length packet kind", (n_ev > base + 16) ? ev_kind[base+16] : -1, 2);
  endtask

  task automatic t_snapshot_full();
    int base, e0;
    set_rdy(1'b0);
    idle(4);
    base = n_ev; e0 = n_exp;
    send(16);
    idle(2);
    flush();
    idle(3);
    set_rdy(1'b1);
    idle(25);
    check_burst("R6", base, e0, 16, 1'b0);
    chk("R6", "events incl. trailing zlp", n_ev - base, 17);
    chk("R6", "trailing zlp kind", (n_ev > base + 16) ? ev_kind[base+16] : -1, 2);
  endtask

  task automatic t_no_dup();
    int base = n_ev;
    flush();
    idle(10);
    flush();
    idle(10);
    chk("R8", "events from redundant flushes", n_ev - base, 0);
  endtask

  task automatic t_timer();
    int base = n_ev, ref_cyc, waited = 0;
    ref_cyc = (n_ev > 0) ? ev_cyc[n_ev-1] : 0;
    send(3);
    while (n_ev < base + 4 && waited < PERIOD + 200) begin
      idle(1);
      waited++;
    end
    chk("R5", "timer closed the packet", n_ev - base, 4);
    if (n_ev >= base + 4) begin
      chk("R5", "timer end kind", ev_kind[base+3], 2);
      chk("R5", "period in window",
          int'(ev_cyc[base+3] - ref_cyc >= PERIOD - 2 && ev_cyc[base+3] - ref_cyc <= PERIOD + 8), 1);
    end
    base = n_ev;
    idle(2 * PERIOD + 20);
    chk("R8", "events from idle timer expiries", n_ev - base, 0);
  endtask

  task automatic t_overflow();
    int base, e0;
    set_rdy(1'b0);
    idle(4);
    base = n_ev; e0 = n_exp;
    send(36);
    idle(2);
    chk("R9", "overflow after drops", int'(overflow), 1);
    chk("R9", "in_ready when full", int'(in_ready), 0);
    chk("R10", "saturated drop count", int'(drop_cnt), 15);
    chk("R9", "words kept", n_exp - e0, 16);
    set_rdy(1'b1);
    idle(25);
    check_burst("R9", base, e0, 16, 1'b0);
    flush();
    idle(10);
    chk("R10", "drop count kept after traffic", int'(drop_cnt), 15);
    chk("R9", "overflow kept after traffic", int'(overflow), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_stream();
    t_short_end();
    t_full_then_zlp();
    t_snapshot_full();
    t_no_dup();
    t_timer();
    t_overflow();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule